// File: doc/BRIEF.md
# Boot Image Segment Loader

This block reads a firmware image from a byte stream, one byte per accepted valid/ready beat, and turns it into word writes toward on-chip memories. A fixed number of leading bytes (the area that holds earlier boot material) is accepted and thrown away. The application image then starts with a 24-byte header. The header carries an identification byte, a segment count and a little-endian entry address. A sequence of segment records follows. Each record has a load address, a byte length and that many payload bytes.

Payload bytes are packed into 32-bit writes with per-byte strobes. Each write goes to one of three memory regions, selected by the address window that holds its load address. Two windows share the flash region, and the others select data RAM and instruction RAM. The write carries the word index inside the selected region. When every segment has been written, the block raises a done flag and presents the entry address as the reset PC. A malformed image raises an error flag instead. Both flags stay set until reset.

Top module: `fw_image_loader`

## Requirements
- R1: The first SKIP_BYTES accepted bytes (default 65536) produce no write and cannot cause an error, whatever their values.
- R2: The first header byte must equal 0xE9. Any other value sets load_error, produces no writes and stops input acceptance.
- R3: Header byte 1 is the segment count. Header bytes 4 to 7 are the entry address, least significant byte first, and entry_pc shows it once load_done is set. Header bytes 2, 3 and 8 to 23 are consumed and have no effect.
- R4: Each segment record is an 8-byte header followed by the payload. The header holds a 32-bit load address and then a 32-bit length, each least significant byte first. The payload is that many bytes, and a length of zero is legal.
- R5: Region code 0 (flash) serves load addresses 0x42000000 to 0x423FFFFF and the alias 0x3C000000 to 0x3C3FFFFF. Region code 1 (data RAM) serves 0x3FC80000 to 0x3FCDFFFF, and region code 2 (instruction RAM) serves 0x4037C000 to 0x403DBFFF. wr_addr is (address minus window base) shifted right by two.
- R6: A payload byte at address A goes to wr_data bits [8*A[1:0]+7 : 8*A[1:0]] with wr_strb bit A[1:0] set. A word is issued when its lane 3 byte arrives or when the segment ends, so unaligned starts and odd lengths give partial strobes.
- R7: A payload byte whose address lies outside every window sets load_error and produces no write for its word. No further bytes are accepted.
- R8: While wr_valid is high and wr_ready is low, in_ready is low and wr_region, wr_addr, wr_data and wr_strb hold their values.
- R9: load_done rises only after the last segment's final write has been accepted (or at once after the header if the count is zero). It then stays high with entry_pc stable, and in_ready stays low.
- R10: load_error is sticky until reset, load_done and load_error are never both high, and reset clears both flags and wr_valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Image byte present |
| in_data | input | 8 | Image byte |
| in_ready | output | 1 | Byte accepted when high together with in_valid |
| wr_valid | output | 1 | Write command present |
| wr_ready | input | 1 | Memory side takes the write |
| wr_region | output | 2 | 0 flash, 1 data RAM, 2 instruction RAM |
| wr_addr | output | WA_W (20) | Word index inside the region |
| wr_data | output | 32 | Packed write data |
| wr_strb | output | 4 | Byte lane enables |
| load_done | output | 1 | Image fully written (sticky) |
| load_error | output | 1 | Malformed image (sticky) |
| entry_pc | output | 32 | Entry address from the header |

## Verification
In a single cycle the write port can retire the pending word while the parser accepts the byte that completes the next word. The output register then has to drop the old word and load the new one with no gap and no duplicate. The bench provokes this with back-to-back full-word payloads under randomly toggled wr_ready and in_valid. It compares every accepted write, in order, against a queue built by a behavioural model of the image, and it checks on every stalled cycle that the held command did not move. A second overlap is termination with a word still in flight. Done must wait for that word, while an error does not cancel a word that was already issued, and the bench checks both against the same queue.

// File: rtl/ldr_pkg.sv
package ldr_pkg;

  typedef enum logic [1:0] {
    RGN_FLASH = 2'd0,
    RGN_DRAM  = 2'd1,
    RGN_IRAM  = 2'd2
  } region_e;

  localparam logic [7:0]  IMG_MAGIC       = 8'hE9;
  localparam int          IMG_HDR_BYTES   = 24;
  localparam int          SEG_HDR_BYTES   = 8;
  localparam int          NUM_WINDOWS     = 4;

  localparam logic [31:0] FLASH_CODE_BASE = 32'h4200_0000;
  localparam logic [31:0] FLASH_DATA_BASE = 32'h3C00_0000;
  localparam logic [31:0] DRAM_BASE       = 32'h3FC8_0000;
  localparam logic [31:0] IRAM_BASE       = 32'h4037_C000;

  typedef enum logic [2:0] {
    P_SKIP, P_HDR, P_SEGH, P_DATA, P_DRAIN, P_DONE, P_FAIL
  } pstate_e;

endpackage

// File: rtl/ldr_parser.sv
module ldr_parser
  import ldr_pkg::*;
#(
  parameter int SKIP_BYTES  = 65536,
  parameter int FLASH_BYTES = 4194304,
  parameter int DRAM_BYTES  = 393216,
  parameter int IRAM_BYTES  = 393216,
  parameter int OFF_W       = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             pack_ok,
  input  logic             pack_idle,
  output logic             in_ready,
  output logic             byte_fire,
  output region_e          byte_rgn,
  output logic [OFF_W-1:0] byte_off,
  output logic             byte_last,
  output logic             done,
  output logic             fail,
  output logic [31:0]      entry_pc
);

  localparam logic [31:0] SKIP_LAST = (SKIP_BYTES > 0) ? 32'(SKIP_BYTES - 1) : 32'd0;
  localparam logic [31:0] HDR_LAST  = 32'(IMG_HDR_BYTES - 1);
  localparam logic [31:0] SEGH_LAST = 32'(SEG_HDR_BYTES - 1);
  localparam pstate_e     ST_INIT   = (SKIP_BYTES > 0) ? P_SKIP : P_HDR;

  localparam logic [31:0] WBASE [NUM_WINDOWS] =
    '{FLASH_CODE_BASE, FLASH_DATA_BASE, DRAM_BASE, IRAM_BASE};
  localparam logic [31:0] WSIZE [NUM_WINDOWS] =
    '{32'(FLASH_BYTES), 32'(FLASH_BYTES), 32'(DRAM_BYTES), 32'(IRAM_BYTES)};
  localparam region_e     WRGN  [NUM_WINDOWS] =
    '{RGN_FLASH, RGN_FLASH, RGN_DRAM, RGN_IRAM};

  pstate_e     st;
  logic [31:0] cnt;
  logic [7:0]  seg_left;
  logic [31:0] cur_addr;
  logic [23:0] len_lo;
  logic [31:0] entry_q;
  logic        accept;
  logic        dec_hit;

  logic [31:0]            wdiff [NUM_WINDOWS];
  logic [NUM_WINDOWS-1:0] whit;

  // One comparator per address window.
  for (genvar k = 0; k < NUM_WINDOWS; k++) begin : g_win
    assign wdiff[k] = cur_addr - WBASE[k];
    assign whit[k]  = (wdiff[k] < WSIZE[k]);
  end

  always_comb begin
    dec_hit  = 1'b0;
    byte_rgn = RGN_FLASH;
    byte_off = '0;
    for (int k = NUM_WINDOWS - 1; k >= 0; k--) begin
      if (whit[k]) begin
        dec_hit  = 1'b1;
        byte_rgn = WRGN[k];
        byte_off = wdiff[k][OFF_W-1:0];
      end
    end
  end

  assign in_ready  = pack_ok && (st == P_SKIP || st == P_HDR || st == P_SEGH || st == P_DATA);
  assign accept    = in_valid && in_ready;
  assign byte_fire = accept && (st == P_DATA) && dec_hit;
  assign byte_last = (cnt == 32'd1);
  assign done      = (st == P_DONE);
  assign fail      = (st == P_FAIL);
  assign entry_pc  = entry_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_INIT;
      cnt      <= '0;
      seg_left <= '0;
      cur_addr <= '0;
      len_lo   <= '0;
      entry_q  <= '0;
    end else begin
      case (st)
        P_SKIP: if (accept) begin
          if (cnt == SKIP_LAST) begin
            st  <= P_HDR;
            cnt <= '0;
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        P_HDR: if (accept) begin
          case (cnt[4:0])
            5'd1: seg_left <= in_byte;
            5'd4: entry_q[7:0]   <= in_byte;
            5'd5: entry_q[15:8]  <= in_byte;
            5'd6: entry_q[23:16] <= in_byte;
            5'd7: entry_q[31:24] <= in_byte;
            default: ;
          endcase
          if (cnt == 32'd0 && in_byte != IMG_MAGIC) begin
            st <= P_FAIL;
          end else if (cnt == HDR_LAST) begin
            cnt <= '0;
            st  <= (seg_left == 8'd0) ? P_DRAIN : P_SEGH;
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        P_SEGH: if (accept) begin
          case (cnt[2:0])
            3'd0: cur_addr[7:0]   <= in_byte;
            3'd1: cur_addr[15:8]  <= in_byte;
            3'd2: cur_addr[23:16] <= in_byte;
            3'd3: cur_addr[31:24] <= in_byte;
            3'd4: len_lo[7:0]     <= in_byte;
            3'd5: len_lo[15:8]    <= in_byte;
            3'd6: len_lo[23:16]   <= in_byte;
            default: ;
          endcase
          if (cnt == SEGH_LAST) begin
            seg_left <= seg_left - 8'd1;
            if ({in_byte, len_lo} == 32'd0) begin
              cnt <= '0;
              st  <= (seg_left == 8'd1) ? P_DRAIN : P_SEGH;
            end else begin
              cnt <= {in_byte, len_lo};
              st  <= P_DATA;
            end
          end else begin
            cnt <= cnt + 32'd1;
          end
        end
        P_DATA: if (accept) begin
          if (!dec_hit) begin
            st <= P_FAIL;
          end else begin
            cur_addr <= cur_addr + 32'd1;
            if (cnt == 32'd1) begin
              cnt <= '0;
              st  <= (seg_left == 8'd0) ? P_DRAIN : P_SEGH;
            end else begin
              cnt <= cnt - 32'd1;
            end
          end
        end
        P_DRAIN: if (pack_idle) st <= P_DONE;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/ldr_packer.sv
module ldr_packer
  import ldr_pkg::*;
#(
  parameter int OFF_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_fire,
  input  region_e          byte_rgn,
  input  logic [OFF_W-1:0] byte_off,
  input  logic             byte_last,
  input  logic [7:0]       byte_data,
  input  logic             wr_ready,
  output logic             pack_ok,
  output logic             pack_idle,
  output logic             wr_valid,
  output logic [1:0]       wr_region,
  output logic [OFF_W-3:0] wr_addr,
  output logic [31:0]      wr_data,
  output logic [3:0]       wr_strb
);

  logic [31:0] acc_data, mrg_data;
  logic [3:0]  acc_strb, mrg_strb;
  logic [1:0]  lane;
  logic        flush;

  assign lane = byte_off[1:0];

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign mrg_data[8*g +: 8] = (lane == 2'(g)) ? byte_data : acc_data[8*g +: 8];
    assign mrg_strb[g]        = (lane == 2'(g)) | acc_strb[g];
  end

  assign flush     = byte_fire && (lane == 2'd3 || byte_last);
  assign pack_ok   = !(wr_valid && !wr_ready);
  assign pack_idle = !wr_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_valid  <= 1'b0;
      wr_region <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_strb   <= '0;
      acc_data  <= '0;
      acc_strb  <= '0;
    end else begin
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (flush) begin
        wr_valid  <= 1'b1;
        wr_region <= byte_rgn;
        wr_addr   <= byte_off[OFF_W-1:2];
        wr_data   <= mrg_data;
        wr_strb   <= mrg_strb;
        acc_data  <= '0;
        acc_strb  <= '0;
      end else if (byte_fire) begin
        acc_data  <= mrg_data;
        acc_strb  <= mrg_strb;
      end
    end
  end

endmodule

// File: rtl/fw_image_loader.sv
module fw_image_loader
  import ldr_pkg::*;
#(
  parameter int SKIP_BYTES  = 65536,
  parameter int FLASH_BYTES = 4194304,
  parameter int DRAM_BYTES  = 393216,
  parameter int IRAM_BYTES  = 393216,
  localparam int MAX_BYTES  = (FLASH_BYTES > DRAM_BYTES)
                              ? ((FLASH_BYTES > IRAM_BYTES) ? FLASH_BYTES : IRAM_BYTES)
                              : ((DRAM_BYTES > IRAM_BYTES) ? DRAM_BYTES : IRAM_BYTES),
  localparam int OFF_W      = $clog2(MAX_BYTES),
  localparam int WA_W       = OFF_W - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  output logic            in_ready,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic [1:0]      wr_region,
  output logic [WA_W-1:0] wr_addr,
  output logic [31:0]     wr_data,
  output logic [3:0]      wr_strb,
  output logic            load_done,
  output logic            load_error,
  output logic [31:0]     entry_pc
);

  logic             pack_ok, pack_idle;
  logic             byte_fire, byte_last;
  region_e          byte_rgn;
  logic [OFF_W-1:0] byte_off;

  ldr_parser #(
    .SKIP_BYTES (SKIP_BYTES),
    .FLASH_BYTES(FLASH_BYTES),
    .DRAM_BYTES (DRAM_BYTES),
    .IRAM_BYTES (IRAM_BYTES),
    .OFF_W      (OFF_W)
  ) i_parser (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_byte  (in_data),
    .pack_ok  (pack_ok),
    .pack_idle(pack_idle),
    .in_ready (in_ready),
    .byte_fire(byte_fire),
    .byte_rgn (byte_rgn),
    .byte_off (byte_off),
    .byte_last(byte_last),
    .done     (load_done),
    .fail     (load_error),
    .entry_pc (entry_pc)
  );

  ldr_packer #(
    .OFF_W(OFF_W)
  ) i_packer (
    .clk      (clk),
    .rst      (rst),
    .byte_fire(byte_fire),
    .byte_rgn (byte_rgn),
    .byte_off (byte_off),
    .byte_last(byte_last),
    .byte_data(in_data),
    .wr_ready (wr_ready),
    .pack_ok  (pack_ok),
    .pack_idle(pack_idle),
    .wr_valid (wr_valid),
    .wr_region(wr_region),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_strb  (wr_strb)
  );

endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int WA_W = 20
) (
  input logic            clk,
  input logic            rst,
  input logic            in_ready,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [1:0]      wr_region,
  input logic [WA_W-1:0] wr_addr,
  input logic [31:0]     wr_data,
  input logic [3:0]      wr_strb,
  input logic            load_done,
  input logic            load_error,
  input logic [31:0]     entry_pc
);

  a_r8_hold_cmd: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)
                                 && $stable(wr_strb) && $stable(wr_region)));

  a_r8_stall_ready: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |-> !in_ready);

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (rst)
    load_done |=> (load_done && $stable(entry_pc)));

  a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
    load_done |-> (!wr_valid && !in_ready));

  a_r10_error_sticky: assert property (@(posedge clk) disable iff (rst)
    load_error |=> (load_error && !in_ready));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(load_done && load_error));

  a_r6_strobe_nonzero: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_strb != 4'd0));

  a_r5_region_code: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_region != 2'd3));

endmodule

bind fw_image_loader ldr_checker #(.WA_W(WA_W)) i_ldr_checker (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_region (wr_region),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_strb   (wr_strb),
  .load_done (load_done),
  .load_error(load_error),
  .entry_pc  (entry_pc)
);

// File: tb/test_fw_image_loader.sv
module test_fw_image_loader;

  localparam int CLK_PERIOD = 10;
  localparam int SKIP_B     = 8;
  localparam int WA_W       = 20;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [7:0]      in_data = '0;
  logic            in_ready;
  logic            wr_valid;
  logic            wr_ready = 1'b0;
  logic [1:0]      wr_region;
  logic [WA_W-1:0] wr_addr;
  logic [31:0]     wr_data;
  logic [3:0]      wr_strb;
  logic            load_done, load_error;
  logic [31:0]     entry_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_image_loader #(.SKIP_BYTES(SKIP_B)) i_fw_image_loader (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_region(wr_region), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_strb(wr_strb), .load_done(load_done), .load_error(load_error),
    .entry_pc(entry_pc)
  );

  typedef struct packed {
    logic [1:0]      r;
    logic [WA_W-1:0] a;
    logic [31:0]     d;
    logic [3:0]      s;
  } wr_t;

  int         n_chk = 0;
  int         n_fail = 0;
  logic [7:0] stream [$];
  wr_t        exp_q [$];
  bit         m_fail;

  task automatic check(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s", msg);
    end
  endtask

  // Address windows written from the requirement text (R5).
  function automatic bit bdec(input logic [31:0] a, output logic [1:0] r, output logic [31:0] off);
    r = 2'd0; off = '0;
    if (a >= 32'h4200_0000 && a < 32'h4240_0000) begin r = 2'd0; off = a - 32'h4200_0000; return 1; end
    if (a >= 32'h3C00_0000 && a < 32'h3C40_0000) begin r = 2'd0; off = a - 32'h3C00_0000; return 1; end
    if (a >= 32'h3FC8_0000 && a < 32'h3FCE_0000) begin r = 2'd1; off = a - 32'h3FC8_0000; return 1; end
    if (a >= 32'h4037_C000 && a < 32'h403D_C000) begin r = 2'd2; off = a - 32'h4037_C000; return 1; end
    return 0;
  endfunction

  task automatic put32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) stream.push_back(v[8*i +: 8]);
  endtask

  task automatic start_image(input logic [7:0] magic, input logic [7:0] nseg, input logic [31:0] entry);
    stream.delete(); exp_q.delete(); m_fail = 0;
    for (int i = 0; i < SKIP_B; i++) stream.push_back((i % 2 == 1) ? 8'hE9 : 8'(8'h10 + i));
    stream.push_back(magic); stream.push_back(nseg);
    stream.push_back(8'h02); stream.push_back(8'h40);
    put32(entry);
    for (int i = 0; i < 16; i++) stream.push_back(8'hA5 ^ 8'(i));
  endtask

  task automatic add_seg(input logic [31:0] addr, input logic [31:0] len);
    logic [31:0] acc_d = '0;
    logic [3:0]  acc_s = '0;
    logic [1:0]  r;
    logic [31:0] off;
    put32(addr); put32(len);
    for (int i = 0; i < int'(len); i++) begin
      logic [31:0] a = addr + 32'(i);
      logic [7:0]  b = (a[7:0] * 8'd13) ^ 8'h5C;
      stream.push_back(b);
      if (!m_fail) begin
        if (!bdec(a, r, off)) m_fail = 1;
        else begin
          acc_d[8*a[1:0] +: 8] = b;
          acc_s[a[1:0]] = 1'b1;
          if (a[1:0] == 2'd3 || i == int'(len) - 1) begin
            exp_q.push_back('{r: r, a: off[WA_W+1:2], d: acc_d, s: acc_s});
            acc_d = '0; acc_s = '0;
          end
        end
      end
    end
  endtask

  task automatic run_case(input string name, input bit exp_done, input logic [31:0] exp_entry,
                          input int rdy_pct, input int val_pct);
    int  ptr = 0, tail = 0, cyc = 0, nwr = 0;
    bit  stall = 0, skip_seen = 0;
    wr_t held = '0, cur;
    @(negedge clk);
    rst = 1; in_valid = 0; wr_ready = 0;
    repeat (2) @(negedge clk);
    check(!load_done && !load_error && !wr_valid,
          $sformatf("R10 %s reset state done=%0b err=%0b wv=%0b exp 0/0/0", name, load_done, load_error, wr_valid));
    rst = 0;
    forever begin
      @(negedge clk);
      cyc++;
      in_valid = (ptr < stream.size()) && ($urandom_range(99) < val_pct);
      in_data  = (ptr < stream.size()) ? stream[ptr] : 8'h00;
      wr_ready = ($urandom_range(99) < rdy_pct);
      #1;
      cur = '{r: wr_region, a: wr_addr, d: wr_data, s: wr_strb};
      if (stall)
        check(wr_valid && cur == held, $sformatf("R8 %s held cmd act=%h exp=%h", name, cur, held));
      if (!skip_seen && ptr >= SKIP_B) begin
        skip_seen = 1;
        check(nwr == 0 && !wr_valid && !load_error,
              $sformatf("R1 %s skip area writes=%0d err=%0b exp 0/0", name, nwr, load_error));
      end
      if (load_done)
        check(!wr_valid && exp_q.size() == 0,
              $sformatf("R9 %s done with wv=%0b pending=%0d exp 0/0", name, wr_valid, exp_q.size()));
      if (load_done || load_error)
        check(!in_ready, $sformatf("R9/R10 %s ready after end act=%0b exp 0", name, in_ready));
      if (wr_valid && wr_ready) begin
        nwr++;
        if (exp_q.size() == 0)
          check(0, $sformatf("R5/R6 %s unexpected write act=%h exp none", name, cur));
        else begin
          wr_t e = exp_q.pop_front();
          check(cur == e, $sformatf("R5/R6 %s write act=%h exp=%h", name, cur, e));
        end
      end
      stall = wr_valid && !wr_ready;
      held  = cur;
      if (in_valid && in_ready) ptr++;
      if ((load_done || load_error) && !wr_valid) tail++;
      if (tail == 4) break;
      if (cyc > 20000) begin
        check(0, $sformatf("R9 %s case watchdog act=timeout exp=finish", name));
        break;
      end
    end
    in_valid = 0;
    check(load_done == exp_done, $sformatf("R9 %s done act=%0b exp=%0b", name, load_done, exp_done));
    check(load_error == !exp_done, $sformatf("R10 %s error act=%0b exp=%0b", name, load_error, !exp_done));
    check(exp_q.size() == 0, $sformatf("R6 %s missing writes act=%0d exp=0", name, exp_q.size()));
    if (exp_done) begin
      check(entry_pc == exp_entry, $sformatf("R3 %s entry act=%h exp=%h", name, entry_pc, exp_entry));
      check(ptr == stream.size(), $sformatf("R4 %s consumed act=%0d exp=%0d", name, ptr, stream.size()));
    end else begin
      check(ptr < stream.size(), $sformatf("R7 %s stopped act=%0d exp<%0d", name, ptr, stream.size()));
    end
  endtask

  task automatic build_main(input logic [31:0] entry);
    start_image(8'hE9, 8'd6, entry);
    add_seg(32'h4200_0001, 32'd6);   // R6 unaligned start
    add_seg(32'h3FC8_0000, 32'd8);   // R5 data RAM, full words
    add_seg(32'h3C00_0010, 32'd0);   // R4 empty segment on the flash alias
    add_seg(32'h4037_C002, 32'd3);   // R5 instruction RAM, odd length
    add_seg(32'h423F_FFFE, 32'd2);   // R5 top of flash window
    add_seg(32'h403D_BFFD, 32'd3);   // R5 top of instruction RAM window
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL global watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // R3 R4 R5 R6: full-rate stream
    build_main(32'h4200_0ABC);
    run_case("main", 1, 32'h4200_0ABC, 100, 100);
    // R8: heavy back-pressure with gappy input
    build_main(32'h4037_C010);
    run_case("backpressure", 1, 32'h4037_C010, 25, 70);
    build_main(32'h3FC8_1234);
    run_case("mixed", 1, 32'h3FC8_1234, 60, 90);
    // R2: wrong identification byte
    start_image(8'hE8, 8'd1, 32'h4200_0000);
    add_seg(32'h4200_0000, 32'd4);
    exp_q.delete();
    run_case("bad_magic", 0, 32'h0, 100, 100);
    // R3 R9: zero segments
    start_image(8'hE9, 8'd0, 32'h4037_C100);
    run_case("no_segments", 1, 32'h4037_C100, 100, 100);
    // R7: segment running past the end of data RAM
    start_image(8'hE9, 8'd2, 32'h4200_0000);
    add_seg(32'h3FCD_FFFE, 32'd4);
    add_seg(32'h4200_0000, 32'd4);
    run_case("window_overrun", 0, 32'h0, 50, 100);
    // R7: segment outside all windows
    start_image(8'hE9, 8'd1, 32'h4200_0000);
    add_seg(32'h6000_0000, 32'd4);
    run_case("no_window", 0, 32'h0, 100, 100);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule